// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page address by walking page tables held in memory. A walk starts from a per-context slot in a context table, found from a root pointer and a context number given as inputs. It then descends through up to three levels of tables, fetching one 32-bit entry per step over a simple request/acknowledge memory port that can also report a read error. An entry may end the walk at the first, second or third table level, which gives a 16 MB, 256 KB or 4 KB mapping.

When the walk reaches a page entry, the block sets the entry's referenced flag if it was clear, and on a write access it also sets the modified flag. If this changes the entry, the block writes it back to the word it was read from. A walk that fails reports a fault code that records both the failure kind and the table level where the walk stopped. A walk that succeeds reports the final entry, the physical page address and a page size code. Only one walk runs at a time. A busy flag covers the whole walk, and a single-cycle done pulse ends it.

Top module: `pgwalk_unit`

## Requirements
- R1: After reset, busy, done and the memory request are all low.
- R2: The first read of a walk goes to byte address (root pointer << 4) + (context number << 2), using the values sampled when the request is accepted.
- R3: A table descriptor's next address is (entry with bits 1:0 cleared) << 4, plus 4 times an index. The index is VA[31:24] for the step into level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: Entry bits 1:0 give the type: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. A page entry ends the walk at level 1, 2 or 3. page_size is then 2 (16 MB), 1 (256 KB) or 0 (4 KB).
- R5: fault_code is 0 on success. On a fault it holds the level (0 for the context table, 1 to 3 for the table levels) in bits 9:8 and a type in bits 4:2, with all other bits zero. An invalid entry gives type 1.
- R6: Fault type 4 is reported for any of these: a reserved entry, a page entry in the context table, a table descriptor at level 3, or a read that returns mem_err.
- R7: phys_addr = (entry[31:8] << 12) + offset. The offset is VA[23:12] << 12 at level 1, VA[17:12] << 12 at level 2, and 0 at level 3.
- R8: The referenced flag is bit 5 and the modified flag is bit 6. The reported entry has bit 5 set, and also bit 6 on a write. If the entry changed, it is written to the address it was read from before done; if it did not change, nothing is written.
- R9: busy rises the cycle after an accepted request and falls with a one-cycle done pulse. Requests seen while busy are ignored.
- R10: mem_req stays high, with mem_addr and mem_we unchanged, until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vpn | input | 20 | Virtual address bits 31:12 |
| req_write | input | 1 | Access is a write |
| root_ptr | input | 32 | Context table root pointer |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 10 | Level and fault type, 0 on success |
| leaf_entry | output | 32 | Final entry with updated flags |
| phys_addr | output | 36 | Physical page address |
| page_size | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 36 | Byte address of the entry |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Read failed (valid with mem_ack) |
| mem_rdata | input | 32 | Read data (valid with mem_ack) |

## Verification
The bench drives walks that end at each of the three table levels, with entries whose flags are clear and entries whose flags are already set, under both read and write accesses. These patterns separate the three offset and size cases and show whether write-back happens or is correctly skipped. Fault walks put an invalid, reserved or wrong-kind entry at every level, and also a failing read in the context table and in a lower table. This shows that each level and each fault type is encoded correctly. Memory latency varies from access to access, and a second request is raised during a walk, to test how requests are held and whether a request made while busy is really ignored.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int VA_W    = 32;
  localparam int PAGE_SH = 12;
  localparam int VPN_W   = VA_W - PAGE_SH;
  localparam int PTE_W   = 32;
  localparam int ROOT_W  = 32;
  localparam int PA_W    = 36;
  localparam int FC_W    = 10;
  localparam int PPN_LO  = 8;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  // vpn slice positions (vpn = VA[31:12])
  localparam int L1_IDX_LO = 12;
  localparam int L2_IDX_LO = 6;
  localparam int L2_IDX_W  = 6;
  localparam int L3_IDX_W  = 6;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_CTX  = 2'd0;
  localparam lvl_t LVL_LAST = 2'd3;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RSVD    = 2'd3
  } etype_t;

  typedef enum logic [1:0] {
    STEP_FAULT,
    STEP_DESCEND,
    STEP_LEAF
  } step_t;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_OTHER   = 3'd4;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;
endpackage

// File: rtl/pgw_entry_decode.sv
module pgw_entry_decode
  import pgw_pkg::*;
(
  input  lvl_t            lvl,
  input  logic [1:0]      etype_bits,
  input  logic            rd_err,
  output step_t           step,
  output logic [FC_W-1:0] fcode
);
  etype_t     et;
  logic [2:0] ftype;

  always_comb begin
    et    = etype_t'(etype_bits);
    ftype = 3'd0;
    step  = STEP_FAULT;
    if (rd_err) begin
      ftype = FT_OTHER;
    end else begin
      case (et)
        ET_INVALID: ftype = FT_INVALID;
        ET_TABLE: begin
          if (lvl == LVL_LAST) ftype = FT_OTHER;
          else                 step  = STEP_DESCEND;
        end
        ET_PAGE: begin
          if (lvl == LVL_CTX) ftype = FT_OTHER;
          else                step  = STEP_LEAF;
        end
        default: ftype = FT_OTHER;
      endcase
    end
    fcode = (step == STEP_FAULT) ? {lvl, 3'b000, ftype, 2'b00} : '0;
  end
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [ROOT_W-1:0]  root_ptr,
  input  logic [CTX_W-1:0]   ctx_num,
  input  logic [VPN_W-1:0]   vpn,
  input  lvl_t               next_lvl,
  input  logic [PTE_W-1:2]   desc_hi,
  output logic [PA_W-1:0]    ctx_addr,
  output logic [PA_W-1:0]    next_addr
);
  localparam int IDX_W = VPN_W - L1_IDX_LO;

  logic [PA_W-1:0]  base;
  logic [IDX_W-1:0] idx;

  always_comb begin
    ctx_addr = (PA_W'(root_ptr) << 4) + (PA_W'(ctx_num) << 2);
    base     = PA_W'({desc_hi, 2'b00}) << 4;
    case (next_lvl)
      2'd1:    idx = vpn[VPN_W-1:L1_IDX_LO];
      2'd2:    idx = IDX_W'(vpn[L2_IDX_LO +: L2_IDX_W]);
      default: idx = IDX_W'(vpn[0 +: L3_IDX_W]);
    endcase
    next_addr = base + (PA_W'(idx) << 2);
  end
endmodule

// File: rtl/pgw_leaf_calc.sv
module pgw_leaf_calc
  import pgw_pkg::*;
(
  input  lvl_t               lvl,
  input  logic [PTE_W-1:0]   entry,
  input  logic [L1_IDX_LO-1:0] vpn_lo,
  input  logic               is_write,
  output logic [PTE_W-1:0]   upd_entry,
  output logic               need_wb,
  output logic [PA_W-1:0]    pa,
  output logic [1:0]         size_code
);
  logic [PA_W-1:0] offset;

  always_comb begin
    case (lvl)
      2'd1: begin
        offset    = PA_W'(vpn_lo) << PAGE_SH;
        size_code = SZ_16M;
      end
      2'd2: begin
        offset    = PA_W'(vpn_lo[L3_IDX_W-1:0]) << PAGE_SH;
        size_code = SZ_256K;
      end
      default: begin
        offset    = '0;
        size_code = SZ_4K;
      end
    endcase
    pa        = (PA_W'(entry[PTE_W-1:PPN_LO]) << PAGE_SH) + offset;
    upd_entry = entry;
    upd_entry[REF_BIT] = 1'b1;
    if (is_write) upd_entry[MOD_BIT] = 1'b1;
    need_wb = (upd_entry != entry);
  end
endmodule

// File: rtl/pgwalk_unit.sv
module pgwalk_unit
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic                req_write,
  input  logic [ROOT_W-1:0]   root_ptr,
  input  logic [CTX_W-1:0]    ctx_num,
  output logic                busy,
  output logic                done,
  output logic [FC_W-1:0]     fault_code,
  output logic [PTE_W-1:0]    leaf_entry,
  output logic [PA_W-1:0]     phys_addr,
  output logic [1:0]          page_size,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PA_W-1:0]     mem_addr,
  output logic [PTE_W-1:0]    mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [PTE_W-1:0]    mem_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WB} st_t;

  st_t               state;
  lvl_t              lvl;
  logic [VPN_W-1:0]  vpn_q;
  logic              wr_q;

  step_t             step;
  logic [FC_W-1:0]   fcode;
  logic [PA_W-1:0]   ctx_addr, next_addr;
  logic [PTE_W-1:0]  upd_entry;
  logic              need_wb;
  logic [PA_W-1:0]   leaf_pa;
  logic [1:0]        leaf_size;
  lvl_t              next_lvl;

  assign next_lvl = lvl_t'(lvl + 2'd1);

  pgw_entry_decode u_dec (
    .lvl        (lvl),
    .etype_bits (mem_rdata[1:0]),
    .rd_err     (mem_err),
    .step       (step),
    .fcode      (fcode)
  );

  pgw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .root_ptr  (root_ptr),
    .ctx_num   (ctx_num),
    .vpn       (vpn_q),
    .next_lvl  (next_lvl),
    .desc_hi   (mem_rdata[PTE_W-1:2]),
    .ctx_addr  (ctx_addr),
    .next_addr (next_addr)
  );

  pgw_leaf_calc u_leaf (
    .lvl       (lvl),
    .entry     (mem_rdata),
    .vpn_lo    (vpn_q[L1_IDX_LO-1:0]),
    .is_write  (wr_q),
    .upd_entry (upd_entry),
    .need_wb   (need_wb),
    .pa        (leaf_pa),
    .size_code (leaf_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lvl        <= LVL_CTX;
      vpn_q      <= '0;
      wr_q       <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      fault_code <= '0;
      leaf_entry <= '0;
      phys_addr  <= '0;
      page_size  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q    <= req_vpn;
            wr_q     <= req_write;
            lvl      <= LVL_CTX;
            mem_addr <= ctx_addr;
            mem_we   <= 1'b0;
            mem_req  <= 1'b1;
            busy     <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            case (step)
              STEP_DESCEND: begin
                lvl      <= next_lvl;
                mem_addr <= next_addr;
              end
              STEP_LEAF: begin
                leaf_entry <= upd_entry;
                phys_addr  <= leaf_pa;
                page_size  <= leaf_size;
                fault_code <= '0;
                if (need_wb) begin
                  mem_we    <= 1'b1;
                  mem_wdata <= upd_entry;
                  state     <= ST_WB;
                end else begin
                  mem_req <= 1'b0;
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  state   <= ST_IDLE;
                end
              end
              default: begin
                fault_code <= fcode;
                leaf_entry <= '0;
                phys_addr  <= '0;
                page_size  <= '0;
                mem_req    <= 1'b0;
                busy       <= 1'b0;
                done       <= 1'b1;
                state      <= ST_IDLE;
              end
            endcase
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an access is held unchanged until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: memory is touched only inside a walk
  p_req_in_walk_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R9: done is a single pulse that closes a busy period
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8: every write-back carries the referenced flag, and the modified flag on writes
  p_wb_ref_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[REF_BIT]);
  p_wb_mod_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && wr_q) |-> mem_wdata[MOD_BIT]);

  // R5: fault codes only use the level field and the two defined types
  p_fault_fmt_r5: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != '0) |->
      ((fault_code[4:2] == FT_INVALID || fault_code[4:2] == FT_OTHER) &&
       fault_code[7:5] == 3'b000 && fault_code[1:0] == 2'b00));

  // R4: a successful walk reports a page entry with the referenced flag
  p_leaf_kind_r4: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == '0) |-> (leaf_entry[1:0] == 2'b10 && leaf_entry[REF_BIT]));
endmodule

// File: tb/pgwalk_unit_tb.sv
module pgwalk_unit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        req_valid;
  logic [19:0] req_vpn;
  logic        req_write;
  logic [31:0] root_ptr;
  logic [7:0]  ctx_num;
  logic        busy, done;
  logic [9:0]  fault_code;
  logic [31:0] leaf_entry;
  logic [35:0] phys_addr;
  logic [1:0]  page_size;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack, mem_err;
  logic [31:0] mem_rdata;

  pgwalk_unit #(.CTX_W(8)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_write(req_write), .root_ptr(root_ptr), .ctx_num(ctx_num),
    .busy(busy), .done(done), .fault_code(fault_code), .leaf_entry(leaf_entry),
    .phys_addr(phys_addr), .page_size(page_size), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [35:0] addr;
    logic [31:0] data;
  } acc_t;

  logic [31:0] mem  [logic [35:0]];
  bit          errs [logic [35:0]];
  acc_t        acc_q[$];

  int checks = 0;
  int errors = 0;
  int done_count = 0;
  int lat = 0, lat_cnt = 0;
  int acc_idx = 0;
  bit outstanding = 0;
  logic [35:0] first_addr;

  logic [9:0]  exp_code;
  logic [31:0] exp_pte;
  logic [35:0] exp_pa;
  logic [1:0]  exp_size;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: walk the bench memory, queue the expected accesses
  task automatic ref_walk(input logic [31:0] va, input bit wr, input logic [7:0] ctx);
    logic [35:0] a;
    logic [31:0] e, ne;
    logic [35:0] off;
    acc_t x;
    exp_code = 0; exp_pte = 0; exp_pa = 0; exp_size = 0;
    a = ({4'b0, root_ptr} * 16) + ({28'b0, ctx} * 4);
    for (int lv = 0; lv < 4; lv++) begin
      x = '{1'b0, a, 32'h0};
      acc_q.push_back(x);
      if (errs.exists(a)) begin
        exp_code = 10'((lv * 256) + 16);
        return;
      end
      e = mem.exists(a) ? mem[a] : 32'h0;
      if (e[1:0] == 2'd0) begin
        exp_code = 10'((lv * 256) + 4);
        return;
      end
      if (e[1:0] == 2'd3 || (e[1:0] == 2'd1 && lv == 3) || (e[1:0] == 2'd2 && lv == 0)) begin
        exp_code = 10'((lv * 256) + 16);
        return;
      end
      if (e[1:0] == 2'd1) begin
        a = {4'b0, e[31:2], 2'b00} * 16;
        if (lv == 0)      a = a + 36'(va[31:24]) * 4;
        else if (lv == 1) a = a + 36'(va[23:18]) * 4;
        else              a = a + 36'(va[17:12]) * 4;
      end else begin
        if (lv == 1)      off = 36'(va[23:12]) * 4096;
        else if (lv == 2) off = 36'(va[17:12]) * 4096;
        else              off = 0;
        exp_size = 2'(3 - lv);
        exp_pa   = 36'(e[31:8]) * 4096 + off;
        ne = e | 32'h20 | (wr ? 32'h40 : 32'h0);
        exp_pte = ne;
        if (ne != e) begin
          x = '{1'b1, a, ne};
          acc_q.push_back(x);
        end
        return;
      end
    end
  endtask

  // memory model and per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        done_count++;
        outstanding = 0;
        chk(acc_q.size() == 0, "R8", "accesses left at done", 64'(acc_q.size()), 64'd0);
      end
      chk(busy == outstanding, "R9", "busy vs model", 64'(busy), 64'(outstanding));
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req) begin
        if (lat_cnt >= lat) begin
          if (acc_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected access", 64'(mem_addr), 64'd0);
          end else begin
            acc_t e;
            e = acc_q.pop_front();
            chk(mem_addr == e.addr, "R3", "access address", 64'(mem_addr), 64'(e.addr));
            chk(mem_we == e.we, "R8", "access kind", 64'(mem_we), 64'(e.we));
            if (e.we) chk(mem_wdata == e.data, "R8", "write-back data", 64'(mem_wdata), 64'(e.data));
          end
          if (acc_idx == 0) first_addr = mem_addr;
          acc_idx++;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            mem_err = 1'b0;
          end else begin
            mem_err   = errs.exists(mem_addr);
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          end
          mem_ack = 1'b1;
          lat_cnt = 0;
          lat = (lat + 1) % 3;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input logic [7:0] ctx,
                      input string tag, input bit poke);
    int c;
    ref_walk(va, wr, ctx);
    acc_idx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = va[31:12]; req_write = wr; ctx_num = ctx;
    @(posedge clk);
    outstanding = 1;
    c = done_count;
    @(negedge clk);
    req_valid = 1'b0; ctx_num = 8'hFF;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_vpn = 20'hFFFFF; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_count == c) @(posedge clk);
    @(negedge clk);
    chk(fault_code == exp_code, tag, "fault_code", 64'(fault_code), 64'(exp_code));
    chk(leaf_entry == exp_pte, tag, "leaf_entry", 64'(leaf_entry), 64'(exp_pte));
    chk(phys_addr == exp_pa, "R7", "phys_addr", 64'(phys_addr), 64'(exp_pa));
    chk(page_size == exp_size, "R4", "page_size", 64'(page_size), 64'(exp_size));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_write = 1'b0;
    root_ptr = 32'h1000; ctx_num = 8'd0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;

    // context table at 0x10000
    mem[36'h1000C] = 32'h0000_2001;  // ctx 3 -> level-1 table 0x20000
    mem[36'h10018] = 32'h0000_0002;  // ctx 6: page entry in context table
    errs[36'h1001C] = 1'b1;          // ctx 7: read error
    // level-1 table at 0x20000
    mem[36'h20048] = 32'h0000_3001;  // VA 0x12xxxxxx -> level-2 table 0x30000
    mem[36'h20100] = 32'h0F00_0022;  // VA 0x40xxxxxx: 16 MB page, referenced
    mem[36'h20140] = 32'h0000_3001;  // VA 0x50xxxxxx -> 0x30000
    mem[36'h20180] = 32'h0000_0003;  // VA 0x60xxxxxx: reserved
    mem[36'h201C0] = 32'h0000_3001;  // VA 0x70xxxxxx -> 0x30000
    mem[36'h201C4] = 32'h0000_6001;  // VA 0x71xxxxxx -> 0x60000 (read error)
    errs[36'h60000] = 1'b1;
    // level-2 table at 0x30000
    mem[36'h30034] = 32'h0000_4001;  // -> level-3 table 0x40000
    mem[36'h30038] = 32'h0000_4001;
    mem[36'h30084] = 32'h00AB_0002;  // 256 KB page
    // level-3 table at 0x40000
    mem[36'h40014] = 32'h0ABC_DE02;  // 4 KB page, flags clear
    mem[36'h40000] = 32'h0000_5001;  // descriptor at last level

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "idle after reset",
        {61'b0, busy, done, mem_req}, 64'd0);

    // 4 KB read, flags clear
    walk(32'h1234_5678, 1'b0, 8'd3, "R8", 1'b0);
    chk(first_addr == 36'h1000C, "R2", "first read address", 64'(first_addr), 64'h1000C);
    chk(leaf_entry == 32'h0ABC_DE22, "R8", "referenced flag set", 64'(leaf_entry), 64'h0ABCDE22);
    chk(phys_addr == 36'h0ABCDE000, "R7", "4 KB address", 64'(phys_addr), 64'h0ABCDE000);
    // same page again: nothing to write
    walk(32'h1234_5000, 1'b0, 8'd3, "R8", 1'b0);
    // write sets modified flag
    walk(32'h1234_5000, 1'b1, 8'd3, "R8", 1'b0);
    chk(leaf_entry == 32'h0ABC_DE62, "R8", "modified flag set", 64'(leaf_entry), 64'h0ABCDE62);
    walk(32'h1234_5000, 1'b1, 8'd3, "R8", 1'b0);
    // 16 MB at level 1, already referenced
    walk(32'h40AB_C000, 1'b0, 8'd3, "R4", 1'b0);
    chk(page_size == 2'd2, "R4", "16 MB size", 64'(page_size), 64'd2);
    // 256 KB at level 2, write, with a request poked in while busy
    walk(32'h5087_F000, 1'b1, 8'd3, "R9", 1'b1);
    chk(phys_addr == 36'h00AB3F000, "R7", "256 KB address", 64'(phys_addr), 64'h00AB3F000);
    repeat (4) @(negedge clk);
    chk(!busy, "R9", "no walk from ignored request", 64'(busy), 64'd0);
    // faults
    walk(32'h0000_0000, 1'b0, 8'd5, "R5", 1'b0);
    chk(fault_code == 10'h004, "R5", "invalid at level 0", 64'(fault_code), 64'h004);
    walk(32'h0000_0000, 1'b0, 8'd6, "R6", 1'b0);
    chk(fault_code == 10'h010, "R6", "page in context table", 64'(fault_code), 64'h010);
    walk(32'h0000_0000, 1'b0, 8'd7, "R6", 1'b0);
    chk(fault_code == 10'h010, "R6", "read error level 0", 64'(fault_code), 64'h010);
    walk(32'h6000_0000, 1'b0, 8'd3, "R6", 1'b0);
    chk(fault_code == 10'h110, "R6", "reserved at level 1", 64'(fault_code), 64'h110);
    walk(32'h7000_0000, 1'b0, 8'd3, "R5", 1'b0);
    chk(fault_code == 10'h204, "R5", "invalid at level 2", 64'(fault_code), 64'h204);
    walk(32'h7100_0000, 1'b0, 8'd3, "R6", 1'b0);
    chk(fault_code == 10'h210, "R6", "read error level 2", 64'(fault_code), 64'h210);
    walk(32'h1238_0000, 1'b0, 8'd3, "R6", 1'b0);
    chk(fault_code == 10'h310, "R6", "descriptor at level 3", 64'(fault_code), 64'h310);
    // R10 hold behaviour is exercised by the varying latency on every access above

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule